// File: doc/BRIEF.md
# Serial Flash Status Register Command Engine

This block is the slave-side control logic of a serial flash device for its status register commands. It samples the serial clock, the active-low chip select, the serial data input and the active-low write-protect pin on the system clock through a synchroniser chain. It shifts in an 8-bit opcode, MSB first, on rising serial clock edges while the chip select is low. It handles three commands: set the write-enable latch, read the status byte, and write the status byte.

A status write is committed only when three conditions hold. The write-enable latch must already be set. Exactly sixteen bits must have been clocked in when the chip select rises. The device must not be in hardware protected mode, which is a set write-disable bit together with a low write-protect pin. A committed write starts a self-timed busy interval of a fixed number of system clocks. The write-in-progress flag shows this interval. While it runs, the status byte can still be read and every other command is ignored. The serial output is driven only while status bits are being shifted out. Outside that window the pad driver is released through an output-enable signal.

Top module: `sr_cmd_engine`

## Requirements
- R1: After reset the status byte reads 00h and `so_oe` is 0.
- R2: Opcode 06h followed by a chip-select rise after exactly 8 bits sets the write-enable latch (status bit 1). Any other bit count, or a busy device (bit 0 = 1), leaves the latch unchanged.
- R3: Opcode 05h returns the status byte MSB first on `so`, with each bit changing after a falling serial clock edge. Every further 8 clocks repeat the byte with its current value. Layout: bit 7 write-disable, bits 6..4 always 0, bit 3 protect-1, bit 2 protect-0, bit 1 write-enable latch, bit 0 write in progress.
- R4: Opcode 01h followed by one data byte commits only when the chip select rises after exactly 16 bits and the write-enable latch was set. Otherwise the status byte is unchanged.
- R5: A committed write copies data bits 7, 3 and 2 into status bits 7, 3 and 2. Data bits 6..4, 1 and 0 have no effect.
- R6: A commit clears the write-enable latch and holds status bit 0 at 1 for `TW_CYCLES` system clocks. During that time the status stays readable, and bit 0 then returns to 0.
- R7: When status bit 7 is 1 and `wp_n` is 0, a status write is rejected and the whole status byte, including the latch, is unchanged. With `wp_n` high the same write is accepted.
- R8: `so_oe` is 1 only in the output phase of a 05h command after its opcode, and it returns to 0 once the chip select is high.
- R9: Opcodes other than 06h, 05h and 01h change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in, MSB first |
| wp_n | input | 1 | Active-low hardware write protect |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the `so` pad driver |

## Verification
On every cycle the assertions check that a busy interval only begins when the write-enable latch was set and hardware protection was off. They also check that protect bits never change without a busy interval starting, that the latch stays clear while busy, and that the output enable drops once the chip select is high. The bench scenarios are the only way to show the exact bit-count rules, the masking of the unused data bits, the MSB-first byte order, and live status re-reads during the busy interval. They also cover commands ignored while busy and the rejection in hardware protected mode.

// File: rtl/sr_pkg.sv
package sr_pkg;
   localparam int BYTE_W = 8;

   localparam logic [BYTE_W-1:0] OP_SET_WE   = 8'h06;
   localparam logic [BYTE_W-1:0] OP_READ_SR  = 8'h05;
   localparam logic [BYTE_W-1:0] OP_WRITE_SR = 8'h01;

   // status bit positions
   localparam int B_WIP  = 0;
   localparam int B_WEL  = 1;
   localparam int B_BP0  = 2;
   localparam int B_BP1  = 3;
   localparam int B_SRWD = 7;

   typedef struct packed {
      logic lock;   // status write disable
      logic bp1;
      logic bp0;
   } prot_t;
endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int CHAIN_W = WIDTH * STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("sr_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("sr_sync: WIDTH must be at least 1");
   end

   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d};
   end

   assign q = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/sr_busy_timer.sv
module sr_busy_timer #(
   parameter int TW_CYCLES = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int TW_W = $clog2(TW_CYCLES + 1);

   if (TW_CYCLES < 1) begin : g_bad_tw
      $error("sr_busy_timer: TW_CYCLES must be at least 1");
   end

   logic [TW_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            left_q <= '0;
      else if (start)        left_q <= TW_W'(TW_CYCLES);
      else if (left_q != '0) left_q <= left_q - 1'b1;
   end

   assign busy = (left_q != '0);

   // R6: a start always yields a busy interval
   a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
endmodule

// File: rtl/sr_cmd_engine.sv
module sr_cmd_engine
   import sr_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int TW_CYCLES   = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic si,
   input  logic wp_n,
   output logic so,
   output logic so_oe
);
   localparam int FRAME_BITS = 2 * BYTE_W;
   localparam int CNT_W      = $clog2(FRAME_BITS) + 1;
   localparam int TXC_W      = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (FRAME_BITS > int'(CNT_MAX)) begin : g_bad_cnt
      $error("sr_cmd_engine: bit counter too narrow");
   end

   // ---------------- input synchronisation ----------------
   logic [3:0] pin_q;
   sr_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sck, si, wp_n}),
      .q     (pin_q)
   );

   logic cs_s, sck_s, si_s, wp_s;
   assign {cs_s, sck_s, si_s, wp_s} = pin_q;

   logic sck_prev_q, cs_prev_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_prev_q <= 1'b0;
         cs_prev_q  <= 1'b1;
      end else begin
         sck_prev_q <= sck_s;
         cs_prev_q  <= cs_s;
      end
   end

   logic sck_rise, sck_fall, cs_rise;
   assign sck_rise = sck_s & ~sck_prev_q & ~cs_s;
   assign sck_fall = ~sck_s & sck_prev_q & ~cs_s;
   assign cs_rise  = cs_s & ~cs_prev_q;

   // ---------------- frame shifting ----------------
   logic [CNT_W-1:0]  bit_cnt_q;
   logic [BYTE_W-1:0] op_q, dat_q;
   logic [BYTE_W-1:0] op_next;

   assign op_next = {op_q[BYTE_W-2:0], si_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt_q <= '0;
         op_q      <= '0;
         dat_q     <= '0;
      end else if (cs_s) begin
         bit_cnt_q <= '0;
      end else if (sck_rise) begin
         if (bit_cnt_q < CNT_W'(BYTE_W)) op_q  <= op_next;
         else                            dat_q <= {dat_q[BYTE_W-2:0], si_s};
         if (bit_cnt_q != CNT_MAX) bit_cnt_q <= bit_cnt_q + 1'b1;
      end
   end

   logic unused_dat;
   assign unused_dat = ^{dat_q[6:4], dat_q[1:0]};

   // ---------------- status state ----------------
   prot_t prot_q;
   logic  wel_q;
   logic  wip;
   logic  hpm;
   logic  wr_ok, we_ok;

   assign hpm   = prot_q.lock & ~wp_s;
   assign wr_ok = cs_rise && (bit_cnt_q == CNT_W'(FRAME_BITS))
                  && (op_q == OP_WRITE_SR) && wel_q && !hpm && !wip;
   assign we_ok = cs_rise && (bit_cnt_q == CNT_W'(BYTE_W))
                  && (op_q == OP_SET_WE) && !wip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_q <= '0;
         wel_q  <= 1'b0;
      end else if (wr_ok) begin
         prot_q <= '{lock: dat_q[B_SRWD], bp1: dat_q[B_BP1], bp0: dat_q[B_BP0]};
         wel_q  <= 1'b0;
      end else if (we_ok) begin
         wel_q  <= 1'b1;
      end
   end

   sr_busy_timer #(.TW_CYCLES(TW_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wr_ok),
      .busy  (wip)
   );

   logic [BYTE_W-1:0] status_word;
   always_comb begin
      status_word         = '0;
      status_word[B_SRWD] = prot_q.lock;
      status_word[B_BP1]  = prot_q.bp1;
      status_word[B_BP0]  = prot_q.bp0;
      status_word[B_WEL]  = wel_q;
      status_word[B_WIP]  = wip;
   end

   // ---------------- status read-out ----------------
   logic              rd_arm_q, oe_q;
   logic [TXC_W-1:0]  tx_cnt_q;
   logic [BYTE_W-1:0] tx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_arm_q <= 1'b0;
         oe_q     <= 1'b0;
         tx_cnt_q <= '0;
         tx_q     <= '0;
      end else if (cs_s) begin
         rd_arm_q <= 1'b0;
         oe_q     <= 1'b0;
         tx_cnt_q <= '0;
      end else begin
         if (sck_rise && bit_cnt_q == CNT_W'(BYTE_W - 1) && op_next == OP_READ_SR)
            rd_arm_q <= 1'b1;
         if (sck_fall && rd_arm_q) begin
            oe_q     <= 1'b1;
            tx_cnt_q <= tx_cnt_q + 1'b1;
            if (tx_cnt_q == '0) tx_q <= status_word;
            else                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
         end
      end
   end

   assign so    = tx_q[BYTE_W-1];
   assign so_oe = oe_q;

   // ---------------- assertions ----------------
   // R4: a busy interval begins only with the latch set
   a_r4_commit_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip) |-> $past(wel_q));
   // R7: no commit in hardware protected mode
   a_r7_no_commit_hpm: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip) |-> !$past(prot_q.lock && !wp_s));
   // R5: protect bits change only together with a commit
   a_r5_prot_with_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(prot_q) |-> $rose(wip));
   // R6: latch stays clear throughout the busy interval
   a_r6_wel_clear_busy: assert property (@(posedge clk) disable iff (!rst_n)
      wip |-> !wel_q);
   // R8: output driver released once the chip select is high
   a_r8_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !so_oe);
endmodule

// File: tb/sr_cmd_engine_tb.sv
module sr_cmd_engine_tb;
   localparam int TW   = 400;
   localparam int HALF = 4;
   localparam int NVEC = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
   logic so, so_oe;

   always #10 clk = ~clk;

   sr_cmd_engine #(.SYNC_STAGES(2), .TW_CYCLES(TW)) u_dut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
      .si(si), .wp_n(wp_n), .so(so), .so_oe(so_oe)
   );

   int checks = 0;
   int errors = 0;
   logic done = 1'b0;
   logic oe_op, oe_mid;

   // {opcode, data, bits, wp_n, expected status}
   localparam logic [29:0] VEC [NVEC] = '{
      {8'h06, 8'h00, 5'd8,  1'b1, 8'h02},  // R2 latch set
      {8'h01, 8'hFF, 5'd16, 1'b1, 8'h8C},  // R5 masked commit
      {8'h01, 8'h00, 5'd16, 1'b1, 8'h8C},  // R4 no latch
      {8'h06, 8'h00, 5'd8,  1'b1, 8'h8E},  // R2
      {8'h01, 8'h00, 5'd15, 1'b1, 8'h8E},  // R4 short frame
      {8'h01, 8'h00, 5'd17, 1'b1, 8'h8E},  // R4 long frame
      {8'h01, 8'h00, 5'd16, 1'b0, 8'h8E},  // R7 protected
      {8'h01, 8'h04, 5'd16, 1'b1, 8'h04},  // R7 pin high accepts
      {8'h06, 8'h00, 5'd8,  1'b1, 8'h06},  // R2
      {8'h9F, 8'h00, 5'd8,  1'b1, 8'h06},  // R9 unknown opcode
      {8'h01, 8'h08, 5'd16, 1'b1, 8'h08},  // R4 commit
      {8'h06, 8'h00, 5'd9,  1'b1, 8'h08}   // R2 wrong length
   };

   function automatic string vec_req(input int i);
      case (i)
         1:          return "R5";
         2, 4, 5, 10: return "R4";
         6, 7:       return "R7";
         9:          return "R9";
         default:    return "R2";
      endcase
   endfunction

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [7:0] op, input logic [7:0] dat,
                       input int nbits, output logic [7:0] rx);
      rx = '0;
      cs_n = 1'b0;
      ticks(HALF);
      for (int i = 0; i < nbits; i++) begin
         si = (i < 8) ? op[7-i] : ((i < 16) ? dat[15-i] : 1'b0);
         ticks(HALF);
         sck = 1'b1;
         if (i == 4)  oe_op  = so_oe;
         if (i == 12) oe_mid = so_oe;
         if (i >= 8)  rx = {rx[6:0], so};
         ticks(HALF);
         sck = 1'b0;
      end
      ticks(HALF);
      cs_n = 1'b1;
      ticks(2 * HALF);
   endtask

   task automatic read_sr(output logic [7:0] s);
      xfer(8'h05, 8'h00, 16, s);
   endtask

   initial begin
      logic [7:0] rx;
      ticks(3);
      check("R1 oe in reset", {7'd0, so_oe}, 8'h00);
      rst_n = 1'b1;
      ticks(3);
      read_sr(rx);
      check("R1 reset status", rx, 8'h00);
      check("R1 oe idle", {7'd0, so_oe}, 8'h00);

      for (int i = 0; i < NVEC; i++) begin
         wp_n = VEC[i][8];
         xfer(VEC[i][29:22], VEC[i][21:14], int'(VEC[i][13:9]), rx);
         ticks(TW + 50);
         read_sr(rx);
         check(vec_req(i), rx, VEC[i][7:0]);
      end
      wp_n = 1'b1;

      // R6 and R3: status readable during busy, repeated byte is live
      xfer(8'h06, 8'h00, 8, rx);
      xfer(8'h01, 8'h00, 16, rx);
      xfer(8'h05, 8'h00, 24, rx);
      check("R6 busy read", rx, 8'h01);
      check("R8 oe off during opcode", {7'd0, oe_op}, 8'h00);
      check("R8 oe on during output", {7'd0, oe_mid}, 8'h01);
      check("R8 oe off after frame", {7'd0, so_oe}, 8'h00);
      ticks(TW + 50);
      read_sr(rx);
      check("R6 busy ended", rx, 8'h00);

      // R2: set-latch command ignored while busy
      xfer(8'h06, 8'h00, 8, rx);
      xfer(8'h01, 8'h8C, 16, rx);
      xfer(8'h06, 8'h00, 8, rx);
      ticks(TW + 50);
      read_sr(rx);
      check("R2 ignored while busy", rx, 8'h8C);

      // R3: MSB-first order with an asymmetric value
      xfer(8'h06, 8'h00, 8, rx);
      read_sr(rx);
      check("R3 bit order", rx, 8'h8E);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule